// File: doc/BRIEF.md
# Ethernet Destination Address Filter

The block examines the first six bytes of each received frame, the destination MAC address, as they stream past one byte per valid cycle. Three collection stages are tried in a fixed order: multicast, then broadcast, then hash table. One verdict comes out per complete address. The verdict says whether the frame is accepted or handed on to the lower-priority logic downstream. It also carries a code naming the stage that accepted it.

Software sets the filter through a small write-only register port. Four 16-bit words form a 64-bit hash table, and a fifth word holds the three stage enables. The enables and the table are captured when a frame starts, so a write made during a frame takes effect only for the next frame.

The sequencer has four states:
- `S_IDLE` (after reset) goes to `S_ADDR` on a start-of-frame byte.
- `S_ADDR` collects bytes. It goes to `S_VERDICT` on the sixth byte, and a fresh start-of-frame keeps it in `S_ADDR` and restarts the count.
- `S_VERDICT` lasts one cycle and drives the verdict. It goes to `S_ADDR` if a start-of-frame arrives in that same cycle, and to `S_DRAIN` otherwise.
- `S_DRAIN` ignores payload bytes and goes to `S_ADDR` on the next start-of-frame.

Top module: `da_filter`

## Requirements
- R1: With the multicast enable set, a frame whose first address byte has bit 0 equal to 1 is accepted with stage code 1. This stage wins over both other stages.
- R2: With the broadcast enable set, a frame whose six address bytes are all FF, and which the multicast stage did not take, is accepted with stage code 2.
- R3: After reset, the control word reads as value 0x0001 (broadcast on; multicast and hash off) and every hash table bit is 0.
- R4: The register port behaves as follows. Address k (k = 0..3) writes table bits 16k+15 down to 16k. Address 4 writes the control word, where bit 0 is the broadcast enable, bit 1 the multicast enable and bit 15 the hash enable. Addresses 5 to 7 and all other control bits are ignored.
- R5: The hash stage works as follows:
  - It runs a CRC-32 with polynomial 04C11DB7 over the six address bytes, starting from all ones. Each byte is fed least significant bit first, and the result is not inverted.
  - CRC bits 28 down to 23 form a pointer that selects one table bit.
  - With the hash enable set and that bit equal to 1, the frame is accepted with stage code 3.
  - Address 01-00-00-00-01-2C gives CRC DA0B4575 hex and pointer 34 hex, which is bit 4 of word 3.
- R6: A frame that no enabled stage accepts gives accept 0 and code 0. With the hash stage enabled, an all-ones table accepts every frame that reaches that stage, and an all-zero table accepts none.
- R7: The done output pulses for exactly one cycle, in the cycle after the sixth address byte is taken. Bytes after the sixth are ignored until the next start-of-frame. A start-of-frame before the sixth byte discards the partial address, which produces no verdict.
- R8: The enables and table used for a frame are those held in the cycle of its start-of-frame byte. A write made in that cycle or later applies only to later frames.
- R9: Outside the done cycle, accept and stage code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame byte is present on in_data |
| in_sof | input | 1 | The present byte is the first byte of a frame |
| in_data | input | 8 | Frame byte, destination address first |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 16 | Register write data |
| v_done | output | 1 | One-cycle verdict strobe |
| v_accept | output | 1 | Frame accepted by a collection stage |
| v_stage | output | 2 | Accepting stage: 0 none, 1 multicast, 2 broadcast, 3 hash |

## Verification
The assertions assume that a start-of-frame is only meaningful together with in_valid. They also assume that the stream gives no other framing signal, so a frame ends only when the next start-of-frame arrives. The stimulus always raises in_sof together with in_valid. It does send stray bytes without a start-of-frame, truncated addresses, payload bytes beyond the sixth, idle gaps, and register writes placed in the start-of-frame cycle and in the middle of an address. These cover every transition of the sequencer.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

    // Positions of the stage enables inside the control word
    localparam int BC_EN_BIT   = 0;
    localparam int MC_EN_BIT   = 1;
    localparam int HASH_EN_BIT = 15;

    typedef enum logic [1:0] {
        STG_NONE  = 2'd0,
        STG_MCAST = 2'd1,
        STG_BCAST = 2'd2,
        STG_HASH  = 2'd3
    } stage_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ADDR,
        S_VERDICT,
        S_DRAIN
    } fsm_e;

    typedef struct packed {
        logic hash_en;
        logic mc_en;
        logic bc_en;
    } en_s;

    // One byte through the CRC, bit 0 first, MSB-feedback register
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[31] ^ b[i];
            r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/dafilt_cfg_regs.sv
module dafilt_cfg_regs
    import dafilt_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int TABLE_WORDS = 4,
    parameter int CFG_AW      = 3,
    localparam int TABLE_BITS = WORD_W * TABLE_WORDS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CFG_AW-1:0]     addr,
    input  logic [WORD_W-1:0]     wdata,
    output en_s                   en_o,
    output logic [TABLE_BITS-1:0] table_o
);

    localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(TABLE_WORDS);

    en_s                   en_q;
    logic [TABLE_BITS-1:0] tab_q;

    for (genvar g = 0; g < TABLE_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tab_q[g*WORD_W +: WORD_W] <= '0;
            end else if (we && addr == CFG_AW'(g)) begin
                tab_q[g*WORD_W +: WORD_W] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '{hash_en: 1'b0, mc_en: 1'b0, bc_en: 1'b1};
        end else if (we && addr == CTRL_ADDR) begin
            en_q <= '{hash_en: wdata[HASH_EN_BIT], mc_en: wdata[MC_EN_BIT], bc_en: wdata[BC_EN_BIT]};
        end
    end

    assign en_o    = en_q;
    assign table_o = tab_q;

    // R4: without a write strobe the configuration holds
    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(tab_q) && $stable(en_q)));

endmodule

// File: rtl/dafilt_crc_acc.sv
module dafilt_crc_acc
    import dafilt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        step,
    input  logic [7:0]  data,
    output logic [31:0] crc_o
);

    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (load) begin
            crc_q <= crc_byte(32'hFFFF_FFFF, data);
        end else if (step) begin
            crc_q <= crc_byte(crc_q, data);
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/dafilt_hash_lookup.sv
module dafilt_hash_lookup #(
    parameter int TABLE_BITS = 64,
    parameter int PTR_HI     = 28,
    localparam int PTR_W     = $clog2(TABLE_BITS)
) (
    input  logic [31:0]           crc_i,
    input  logic [TABLE_BITS-1:0] table_i,
    output logic [PTR_W-1:0]      ptr_o,
    output logic                  hit_o
);

    assign ptr_o = crc_i[PTR_HI -: PTR_W];
    assign hit_o = table_i[ptr_o];

endmodule

// File: rtl/da_filter.sv
module da_filter
    import dafilt_pkg::*;
#(
    parameter int ADDR_BYTES  = 6,
    parameter int WORD_W      = 16,
    parameter int TABLE_WORDS = 4,
    parameter int CFG_AW      = 3,
    parameter int PTR_HI      = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [7:0]        in_data,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              v_done,
    output logic              v_accept,
    output logic [1:0]        v_stage
);

    localparam int TABLE_BITS = WORD_W * TABLE_WORDS;
    localparam int PTR_W      = $clog2(TABLE_BITS);
    localparam int CW         = $clog2(ADDR_BYTES + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(ADDR_BYTES - 1);

    fsm_e                  state_q, state_d;
    logic [CW-1:0]         cnt_q;
    logic                  mc_q, bc_q;
    en_s                   cfg_en, snap_en_q;
    logic [TABLE_BITS-1:0] cfg_tab, snap_tab_q;
    logic [31:0]           crc;
    logic [PTR_W-1:0]      ptr;
    logic                  hash_hit;
    stage_e                stage;

    wire take_sof  = in_valid & in_sof;
    wire take_byte = in_valid & ~in_sof & (state_q == S_ADDR);

    dafilt_cfg_regs #(
        .WORD_W(WORD_W), .TABLE_WORDS(TABLE_WORDS), .CFG_AW(CFG_AW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .en_o(cfg_en), .table_o(cfg_tab)
    );

    dafilt_crc_acc u_crc (
        .clk(clk), .rst_n(rst_n), .load(take_sof), .step(take_byte),
        .data(in_data), .crc_o(crc)
    );

    dafilt_hash_lookup #(
        .TABLE_BITS(TABLE_BITS), .PTR_HI(PTR_HI)
    ) u_hash (
        .crc_i(crc), .table_i(snap_tab_q), .ptr_o(ptr), .hit_o(hash_hit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (take_sof) state_d = S_ADDR;
            S_ADDR:    if (take_byte && cnt_q == LAST_CNT) state_d = S_VERDICT;
            S_VERDICT: state_d = take_sof ? S_ADDR : S_DRAIN;
            S_DRAIN:   if (take_sof) state_d = S_ADDR;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Per-frame capture: byte count, address flags, configuration snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            mc_q       <= 1'b0;
            bc_q       <= 1'b0;
            snap_en_q  <= '0;
            snap_tab_q <= '0;
        end else if (take_sof) begin
            cnt_q      <= CW'(1);
            mc_q       <= in_data[0];
            bc_q       <= &in_data;
            snap_en_q  <= cfg_en;
            snap_tab_q <= cfg_tab;
        end else if (take_byte) begin
            cnt_q <= cnt_q + CW'(1);
            bc_q  <= bc_q & (&in_data);
        end
    end

    // Outputs: priority chain evaluated in the verdict state
    always_comb begin
        stage = STG_NONE;
        unique case (state_q)
            S_VERDICT: begin
                if (snap_en_q.mc_en && mc_q)              stage = STG_MCAST;
                else if (snap_en_q.bc_en && bc_q)         stage = STG_BCAST;
                else if (snap_en_q.hash_en && hash_hit)   stage = STG_HASH;
            end
            S_IDLE, S_ADDR, S_DRAIN: stage = STG_NONE;
            default: stage = STG_NONE;
        endcase
        v_done   = (state_q == S_VERDICT);
        v_accept = (stage != STG_NONE);
        v_stage  = stage;
    end

    // R7: done is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        v_done |=> !v_done);

    // R7: a verdict always follows a byte taken on the previous edge
    a_r7_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_done) |-> $past(in_valid));

    // R7: byte count never exceeds the address length
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(ADDR_BYTES));

    // R8: snapshot frozen while an address is being collected
    a_r8_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR && !take_sof) |=> ($stable(snap_tab_q) && $stable(snap_en_q)));

    // R1: broadcast never reported when multicast would have taken the frame
    a_r1_mcast_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (v_done && v_stage == STG_BCAST) |-> !(snap_en_q.mc_en && mc_q));

    // R9: quiet outputs outside the verdict cycle
    a_r9_quiet_outside_done: assert property (@(posedge clk) disable iff (!rst_n)
        !v_done |-> (!v_accept && v_stage == 2'd0));

endmodule

// File: tb/test_da_filter.sv
module test_da_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        v_done, v_accept;
    logic [1:0]  v_stage;

    always #5 clk = ~clk;

    da_filter i_da_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .v_done(v_done), .v_accept(v_accept), .v_stage(v_stage)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string note     = "";

    // Reference model state
    bit        m_mc = 0, m_bc = 1, m_hash = 0;
    bit [63:0] m_tab = '0;
    bit        s_mc, s_bc, s_hash;
    bit [63:0] s_tab;
    int        q[$];
    bit        active = 0;
    int        exp_done = 0, exp_stage = 0;

    function automatic int unsigned ref_crc(input int b[$]);
        int unsigned c = 32'hFFFF_FFFF;
        foreach (b[k]) begin
            for (int j = 0; j < 8; j++) begin
                int unsigned fb = ((c >> 31) & 1) ^ ((b[k] >> j) & 1);
                c = (c << 1) ^ (fb != 0 ? 32'h04C11DB7 : 32'h0);
            end
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp_v, $time);
        end
    endtask

    task automatic model_edge(input bit iv, input bit is, input int d,
                              input bit we, input int a, input int wd);
        exp_done  = 0;
        exp_stage = 0;
        if (iv && is) begin
            s_mc = m_mc; s_bc = m_bc; s_hash = m_hash; s_tab = m_tab;
            q = {};
            q.push_back(d);
            active = 1;
        end else if (iv && active) begin
            q.push_back(d);
            if (q.size() == 6) begin
                int unsigned c   = ref_crc(q);
                int          ptr = (c >> 23) & 63;
                bit          all_ff = 1;
                foreach (q[k]) if (q[k] != 8'hFF) all_ff = 0;
                exp_done = 1;
                if (s_mc && (q[0] & 1)) exp_stage = 1;
                else if (s_bc && all_ff) exp_stage = 2;
                else if (s_hash && s_tab[ptr]) exp_stage = 3;
                active = 0;
            end
        end
        if (we) begin
            if (a < 4) m_tab[a*16 +: 16] = wd[15:0];
            else if (a == 4) begin
                m_bc = wd[0]; m_mc = wd[1]; m_hash = wd[15];
            end
        end
    endtask

    task automatic cyc(input bit iv, input bit is, input int d,
                       input bit we = 0, input int a = 0, input int wd = 0);
        in_valid = iv; in_sof = is; in_data = d[7:0];
        cfg_we = we; cfg_addr = a[2:0]; cfg_wdata = wd[15:0];
        @(posedge clk);
        model_edge(iv, is, d, we, a, wd);
        @(negedge clk);
        begin
            string tg_d = (note != "") ? note : "R7";
            string tg_s = (note != "") ? note :
                          (exp_done == 0) ? "R9" :
                          (exp_stage == 1) ? "R1" : (exp_stage == 2) ? "R2" :
                          (exp_stage == 3) ? "R5" : "R6";
            check(v_done == exp_done[0], tg_d, v_done, exp_done);
            check(v_stage == exp_stage[1:0] && v_accept == (exp_stage != 0), tg_s,
                  {v_accept, v_stage}, {exp_stage != 0, exp_stage[1:0]});
        end
        in_valid = 0; in_sof = 0; cfg_we = 0;
    endtask

    task automatic wr(input int a, input int wd);
        cyc(0, 0, 0, 1, a, wd);
    endtask

    task automatic frame(input logic [47:0] da, input int extra = 1);
        for (int i = 0; i < 6; i++) cyc(1, i == 0, da[47-8*i -: 8]);
        for (int i = 0; i < extra; i++) cyc(1, 0, 8'h5A + i);
        cyc(0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] lfsr = 48'h1234_5678_9ABC;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        cyc(0, 0, 0);

        // R3: reset defaults, multicast and hash off, broadcast on
        note = "R3";
        frame(48'h01005E000001);
        frame(48'hFFFFFFFFFFFF);
        frame(48'h01000000012C);
        note = "";

        // R1: multicast enabled, takes precedence over broadcast
        wr(4, 16'h0003);
        frame(48'h01005E7F0001);
        frame(48'hFFFFFFFFFFFF);
        frame(48'h0200AABBCCDD);   // unicast, R6
        // R2: broadcast only
        wr(4, 16'h0001);
        frame(48'hFFFFFFFFFFFF);
        frame(48'hFFFFFFFFFFFE);

        // R5: test vector through the hash stage
        begin
            int tv[$] = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h2C};
            int unsigned c = ref_crc(tv);
            check(c == 32'hDA0B4575, "R5", c, 32'hDA0B4575);
            check(((c >> 23) & 63) == 32'h34, "R5", (c >> 23) & 63, 32'h34);
        end
        wr(4, 16'h8000);
        wr(3, 16'h0010);
        frame(48'h01000000012C);
        wr(3, 16'hFFEF);
        wr(0, 16'hFFFF); wr(1, 16'hFFFF); wr(2, 16'hFFFF);
        frame(48'h01000000012C);    // every bit but 0x34: rejected

        // R6: all ones accepts everything, all zero nothing
        wr(3, 16'hFFFF);
        for (int i = 0; i < 8; i++) begin
            lfsr = {lfsr[46:0], lfsr[47] ^ lfsr[46] ^ lfsr[20] ^ lfsr[19]};
            frame(lfsr, i % 3);
        end
        for (int k = 0; k < 4; k++) wr(k, 0);
        for (int i = 0; i < 8; i++) begin
            lfsr = {lfsr[46:0], lfsr[47] ^ lfsr[46] ^ lfsr[20] ^ lfsr[19]};
            frame(lfsr);
        end

        // R4: writes to unused addresses and unused control bits ignored
        note = "R4";
        wr(5, 16'hFFFF); wr(6, 16'hFFFF); wr(7, 16'hFFFF);
        wr(4, 16'h7FFC);            // all three enables cleared
        frame(48'hFFFFFFFFFFFF);
        frame(48'h01005E000001);
        note = "";

        // R7: truncated address, stray bytes, restart, back-to-back sof
        wr(4, 16'h8003);
        wr(2, 16'hFFFF);
        note = "R7";
        cyc(1, 0, 8'h11); cyc(1, 0, 8'h22);       // no sof: ignored
        cyc(1, 1, 8'h01); cyc(1, 0, 8'h00); cyc(1, 0, 8'h00);
        frame(48'hFFFFFFFFFFFF, 4);
        for (int i = 0; i < 6; i++) cyc(1, i == 0, 8'h30 + i);
        cyc(1, 1, 8'h01);                          // sof in the verdict cycle
        for (int i = 1; i < 6; i++) cyc(1, 0, 8'h40 + i);
        cyc(0, 0, 0);
        note = "";

        // R8: write in the sof cycle and mid-address apply to the next frame
        note = "R8";
        for (int k = 0; k < 4; k++) wr(k, 0);
        wr(4, 16'h8000);
        cyc(1, 1, 8'h02, 1, 0, 16'hFFFF);
        cyc(1, 0, 8'h10, 1, 1, 16'hFFFF);
        cyc(1, 0, 8'h20, 1, 2, 16'hFFFF);
        cyc(1, 0, 8'h30, 1, 3, 16'hFFFF);
        cyc(1, 0, 8'h40, 1, 4, 16'h0003);
        cyc(1, 0, 8'h50);
        cyc(0, 0, 0);
        frame(48'h021020304050);
        frame(48'hFFFFFFFFFFFF);
        note = "";

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule